// File: doc/BRIEF.md
# UART Receive/Transmit Queue and Interrupt Identification

This block holds the two byte queues of a serial port together with the logic that tells the host why the port wants attention. Received bytes come in from a deserializer and leave through host reads. Bytes the host writes leave towards a serializer. A write to the FIFO control register turns queue mode on or off, empties either queue, and picks how full the receive queue must be before the host is interrupted.

The interrupt identification value reports one pending cause at a time. The first cause is received data at or above the chosen fill level. The second is a receive timeout: unread bytes remain and nothing has moved for several character times. The third is a transmit queue that has run completely dry. When queue mode is off, each queue acts as a one-byte holding register and a single received byte is enough to interrupt. An interrupt request output is high whenever a cause is reported.

Top module: `uart_fifo_intc`

## Requirements
- R1: A control write with bit 0 = 1 turns queue mode on and loads the trigger select from bits 7:6. In the same write, bit 1 empties the receive queue and bit 2 empties the transmit queue, for that one write only. A control write with bit 0 = 0 turns queue mode off and its other bits have no effect. Any write that changes the mode empties both queues.
- R2: Each queue is first-in first-out and holds 16 bytes in queue mode and 1 byte otherwise. While a queue is not empty its oldest byte is shown on its pop data output.
- R3: A receive push into a full receive queue with no pop in the same cycle is dropped, and `rx_overrun` is high in that cycle. A push together with a pop on a full queue is accepted.
- R4: The receive-data code 0100 in IIR bits 3:0 is reported while the receive fill is at or above the level. The level is 1, 4, 8 or 14 bytes for trigger select 00, 01, 10 or 11 in queue mode, and it is 1 when queue mode is off.
- R5: In queue mode, when the receive queue is not empty and 4 `char_tick` pulses have passed with no receive push, pop or flush, the timeout code 1100 is reported. Any receive push, pop or flush restarts the count.
- R6: The transmit-empty source is set on the cycle the transmit queue goes from non-empty to empty. It is cleared by an accepted transmit push, or by an IIR read while code 0010 is reported.
- R7: IIR bits 3:0 report, in this priority, 0100 (receive level, needs `ie_rx`), 1100 (timeout, needs `ie_rx`), 0010 (transmit empty, needs `ie_tx`), and otherwise 0001. `irq` is high exactly when the code is not 0001.
- R8: IIR bits 7:6 read 11 in queue mode and 00 otherwise, and bits 5:4 read 0. After reset, queue mode is off, both queues are empty, and the IIR reads 0x01.
- R9: A pop from an empty queue is ignored. `tx_full` is high when the transmit queue holds its capacity, and `tx_empty` and `rx_empty` are high when the queue holds nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fcr_wr | input | 1 | Control register write strobe |
| fcr_wdata | input | 8 | Control register write data |
| iir_rd | input | 1 | Identification register read strobe |
| iir_rdata | output | 8 | Identification register value |
| ie_rx | input | 1 | Enable for receive-level and timeout causes |
| ie_tx | input | 1 | Enable for transmit-empty cause |
| irq | output | 1 | Interrupt request |
| rx_push | input | 1 | Byte from the deserializer |
| rx_push_data | input | 8 | Received byte |
| rx_overrun | output | 1 | Receive byte dropped this cycle |
| rx_pop | input | 1 | Host read of received data |
| rx_pop_data | output | 8 | Oldest received byte |
| rx_empty | output | 1 | Receive queue empty |
| tx_push | input | 1 | Host write of a byte to send |
| tx_push_data | input | 8 | Byte to send |
| tx_full | output | 1 | Transmit queue full |
| tx_pop | input | 1 | Serializer takes a byte |
| tx_pop_data | output | 8 | Oldest byte to send |
| tx_empty | output | 1 | Transmit queue empty |
| char_tick | input | 1 | One pulse per character time |

## Verification
Queue contents, pop data, empty and full flags, the identification value and `irq` all change one clock after the edge that applies a push, pop, control write or IIR read. `rx_overrun` is valid in the same cycle as the push that causes it. The timeout code appears one clock after the edge that takes the fourth quiet `char_tick`. The bench drives every input just after a falling edge and compares just after that, so the values it sees are the ones registered at the previous rising edge. It then lets a reference model take the same rising edge and compares again after the next falling edge.

// File: rtl/uart_fi_pkg.sv
package uart_fi_pkg;

  typedef enum logic [3:0] {
    IID_NONE = 4'b0001,
    IID_THRE = 4'b0010,
    IID_RXD  = 4'b0100,
    IID_CTO  = 4'b1100
  } iid_e;

  // receive interrupt level in bytes for a trigger select and mode
  function automatic logic [7:0] rx_level(input logic [1:0] sel, input logic fifo_on);
    logic [7:0] lv;
    if (!fifo_on) lv = 8'd1;
    else begin
      case (sel)
        2'b00:   lv = 8'd1;
        2'b01:   lv = 8'd4;
        2'b10:   lv = 8'd8;
        default: lv = 8'd14;
      endcase
    end
    return lv;
  endfunction

  // priority pick of the reported cause
  function automatic iid_e iid_pick(input logic rx_hit, input logic cto, input logic thre);
    iid_e c;
    if (rx_hit)    c = IID_RXD;
    else if (cto)  c = IID_CTO;
    else if (thre) c = IID_THRE;
    else           c = IID_NONE;
    return c;
  endfunction

endpackage

// File: rtl/uart_fi_fifo.sv
module uart_fi_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          single,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          push_ok,
  output logic          pop_ok,
  output logic          full,
  output logic          empty
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cap;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign cap     = single ? CW'(1) : CW'(DEPTH);
  assign full    = (count >= cap);
  assign empty   = (count == '0);
  assign pop_ok  = pop && !empty && !flush;
  assign push_ok = push && (!full || pop_ok) && !flush;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_next(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R2
  cap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) count <= cap);

  // R1
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n) flush |=> count == '0);

  // R3
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> $stable(count));

endmodule

// File: rtl/uart_fi_timeout.sv
module uart_fi_timeout #(
  parameter int TICKS = 4,
  localparam int TW   = $clog2(TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic activity,
  input  logic tick,
  output logic expired
);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (!arm || activity)    cnt <= '0;
    else if (tick && cnt != TW'(TICKS)) cnt <= cnt + 1'b1;
  end

  assign expired = arm && (cnt == TW'(TICKS));

  // R5
  cto_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(expired) |-> $past(tick));

  // R5
  cto_count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt <= TW'(TICKS));

endmodule

// File: rtl/uart_fi_iir.sv
module uart_fi_iir
  import uart_fi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fifo_en,
  input  logic       rx_hit,
  input  logic       cto,
  input  logic       tx_drained,
  input  logic       tx_push_ok,
  input  logic       iir_rd,
  input  logic       ie_rx,
  input  logic       ie_tx,
  output logic [7:0] iir,
  output logic       irq,
  output logic       thre_pend
);

  iid_e code;

  assign code = iid_pick(rx_hit && ie_rx, cto && ie_rx, thre_pend && ie_tx);
  assign iir  = {fifo_en, fifo_en, 2'b00, code};
  assign irq  = (code != IID_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          thre_pend <= 1'b0;
    else if (tx_drained)                 thre_pend <= 1'b1;
    else if (tx_push_ok)                 thre_pend <= 1'b0;
    else if (iir_rd && code == IID_THRE) thre_pend <= 1'b0;
  end

  // R6
  thre_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rd && iir[3:0] == 4'b0010 && !tx_drained) |=> !thre_pend);

  // R7
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie_rx && !ie_tx) |-> !irq);

endmodule

// File: rtl/uart_fifo_intc.sv
module uart_fifo_intc
  import uart_fi_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int TO_TICKS = 4,
  localparam int CW      = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fcr_wr,
  input  logic [7:0] fcr_wdata,
  input  logic       iir_rd,
  output logic [7:0] iir_rdata,
  input  logic       ie_rx,
  input  logic       ie_tx,
  output logic       irq,
  input  logic       rx_push,
  input  logic [7:0] rx_push_data,
  output logic       rx_overrun,
  input  logic       rx_pop,
  output logic [7:0] rx_pop_data,
  output logic       rx_empty,
  input  logic       tx_push,
  input  logic [7:0] tx_push_data,
  output logic       tx_full,
  input  logic       tx_pop,
  output logic [7:0] tx_pop_data,
  output logic       tx_empty,
  input  logic       char_tick
);

  logic          fifo_en;
  logic [1:0]    trig_sel;
  logic          fcr_take, mode_chg, rx_flush, tx_flush;
  logic          unused_fcr_bits;
  logic [CW-1:0] rx_count, tx_count;
  logic          rx_push_ok, rx_pop_ok, rx_full;
  logic          tx_push_ok, tx_pop_ok;
  logic          rx_hit, cto, tx_drained, thre_pend;

  // control write decode
  assign fcr_take        = fcr_wr && fcr_wdata[0];
  assign mode_chg        = fcr_wr && (fcr_wdata[0] != fifo_en);
  assign rx_flush        = mode_chg || (fcr_take && fcr_wdata[1]);
  assign tx_flush        = mode_chg || (fcr_take && fcr_wdata[2]);
  assign unused_fcr_bits = ^fcr_wdata[5:3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_en  <= 1'b0;
      trig_sel <= 2'b00;
    end else if (fcr_wr) begin
      fifo_en <= fcr_wdata[0];
      if (fcr_take) trig_sel <= fcr_wdata[7:6];
    end
  end

  uart_fi_fifo #(.DW(8), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush), .single(!fifo_en),
    .push(rx_push), .push_data(rx_push_data), .pop(rx_pop),
    .head(rx_pop_data), .count(rx_count), .push_ok(rx_push_ok),
    .pop_ok(rx_pop_ok), .full(rx_full), .empty(rx_empty)
  );

  uart_fi_fifo #(.DW(8), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush), .single(!fifo_en),
    .push(tx_push), .push_data(tx_push_data), .pop(tx_pop),
    .head(tx_pop_data), .count(tx_count), .push_ok(tx_push_ok),
    .pop_ok(tx_pop_ok), .full(tx_full), .empty(tx_empty)
  );

  assign rx_overrun = rx_push && rx_full && !rx_pop_ok && !rx_flush;
  assign rx_hit     = (8'(rx_count) >= rx_level(trig_sel, fifo_en));
  assign tx_drained = (tx_pop_ok && !tx_push_ok && tx_count == CW'(1)) ||
                      (tx_flush && !tx_empty);

  uart_fi_timeout #(.TICKS(TO_TICKS)) u_cto (
    .clk(clk), .rst_n(rst_n), .arm(fifo_en && !rx_empty),
    .activity(rx_push_ok || rx_pop_ok || rx_flush),
    .tick(char_tick), .expired(cto)
  );

  uart_fi_iir u_iir (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_hit(rx_hit), .cto(cto),
    .tx_drained(tx_drained), .tx_push_ok(tx_push_ok), .iir_rd(iir_rd),
    .ie_rx(ie_rx), .ie_tx(ie_tx), .iir(iir_rdata), .irq(irq), .thre_pend(thre_pend)
  );

  // R3
  overrun_keeps_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |=> rx_count == $past(rx_count));

  // R5
  cto_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iir_rdata[3] |-> (iir_rdata[2] && fifo_en && !rx_empty));

  // R6
  thre_on_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(thre_pend) |-> tx_empty);

  // R4
  single_byte_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_rx && !fifo_en && !rx_empty) |-> iir_rdata[3:0] == 4'b0100);

  // R1
  mode_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (rx_empty && tx_empty));

endmodule

// File: tb/test_uart_fifo_intc.sv
`timescale 1ns/1ps
module test_uart_fifo_intc;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fcr_wr = 0, iir_rd = 0, ie_rx = 0, ie_tx = 0;
  logic [7:0] fcr_wdata = 0, rx_push_data = 0, tx_push_data = 0;
  logic rx_push = 0, rx_pop = 0, tx_push = 0, tx_pop = 0, char_tick = 0;
  logic [7:0] iir_rdata, rx_pop_data, tx_pop_data;
  logic irq, rx_overrun, rx_empty, tx_full, tx_empty;

  always #2.5 clk = ~clk;

  uart_fifo_intc i_uart_fifo_intc (
    .clk(clk), .rst_n(rst_n), .fcr_wr(fcr_wr), .fcr_wdata(fcr_wdata),
    .iir_rd(iir_rd), .iir_rdata(iir_rdata), .ie_rx(ie_rx), .ie_tx(ie_tx),
    .irq(irq), .rx_push(rx_push), .rx_push_data(rx_push_data),
    .rx_overrun(rx_overrun), .rx_pop(rx_pop), .rx_pop_data(rx_pop_data),
    .rx_empty(rx_empty), .tx_push(tx_push), .tx_push_data(tx_push_data),
    .tx_full(tx_full), .tx_pop(tx_pop), .tx_pop_data(tx_pop_data),
    .tx_empty(tx_empty), .char_tick(char_tick)
  );

  int checks = 0, errors = 0;
  logic [7:0] rxq[$], txq[$];
  bit m_en = 0, m_pend = 0;
  bit [1:0] m_trig = 0;
  int m_cnt = 0;

  function automatic int exp_level();
    if (!m_en) return 1;
    case (m_trig)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  function automatic int exp_cap();
    return m_en ? 16 : 1;
  endfunction

  function automatic bit [3:0] exp_code();
    if (ie_rx && rxq.size() >= exp_level()) return 4'b0100;
    if (ie_rx && m_en && rxq.size() > 0 && m_cnt >= 4) return 4'b1100;
    if (ie_tx && m_pend) return 4'b0010;
    return 4'b0001;
  endfunction

  function automatic bit exp_rx_flush();
    bit chg = fcr_wr && (fcr_wdata[0] != m_en);
    return chg || (fcr_wr && fcr_wdata[0] && fcr_wdata[1]);
  endfunction

  function automatic bit exp_tx_flush();
    bit chg = fcr_wr && (fcr_wdata[0] != m_en);
    return chg || (fcr_wr && fcr_wdata[0] && fcr_wdata[2]);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare_now();
    bit [7:0] e_iir = {m_en, m_en, 2'b00, exp_code()};
    bit e_ovr = !exp_rx_flush() && rx_push && rxq.size() >= exp_cap() &&
                !(rx_pop && rxq.size() > 0);
    chk(iir_rdata == e_iir, "R7 iir", iir_rdata, e_iir);
    chk(irq == (e_iir[3:0] != 4'b0001), "R7 irq", irq, e_iir[3:0] != 4'b0001);
    chk(rx_overrun == e_ovr, "R3 overrun", rx_overrun, e_ovr);
    chk(rx_empty == (rxq.size() == 0), "R9 rx_empty", rx_empty, rxq.size() == 0);
    chk(tx_empty == (txq.size() == 0), "R9 tx_empty", tx_empty, txq.size() == 0);
    chk(tx_full == (txq.size() >= exp_cap()), "R9 tx_full", tx_full, txq.size() >= exp_cap());
    if (rxq.size() > 0) chk(rx_pop_data == rxq[0], "R2 rx head", rx_pop_data, rxq[0]);
    if (txq.size() > 0) chk(tx_pop_data == txq[0], "R2 tx head", tx_pop_data, txq[0]);
  endtask

  task automatic model_edge();
    bit [3:0] code_now = exp_code();
    bit rfl = exp_rx_flush(), tfl = exp_tx_flush();
    int c = exp_cap();
    bit armed = m_en && rxq.size() > 0;
    bit rx_act = 0, popok, pushok, tpushok = 0;
    int tb = txq.size();
    if (rfl) begin
      rxq.delete(); rx_act = 1;
    end else begin
      popok  = rx_pop && rxq.size() > 0;
      pushok = rx_push && (rxq.size() < c || popok);
      if (popok) void'(rxq.pop_front());
      if (pushok) rxq.push_back(rx_push_data);
      rx_act = popok || pushok;
    end
    if (!armed || rx_act) m_cnt = 0;
    else if (char_tick && m_cnt < 4) m_cnt++;
    if (tfl) txq.delete();
    else begin
      popok   = tx_pop && txq.size() > 0;
      tpushok = tx_push && (txq.size() < c || popok);
      if (popok) void'(txq.pop_front());
      if (tpushok) txq.push_back(tx_push_data);
    end
    if (tb > 0 && txq.size() == 0) m_pend = 1;
    else if (tpushok) m_pend = 0;
    else if (iir_rd && code_now == 4'b0010) m_pend = 0;
    if (fcr_wr) begin
      m_en = fcr_wdata[0];
      if (fcr_wdata[0]) m_trig = fcr_wdata[7:6];
    end
  endtask

  // inputs already set just after a falling edge
  task automatic step();
    #1;
    compare_now();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    fcr_wr = 0; iir_rd = 0; rx_push = 0; rx_pop = 0;
    tx_push = 0; tx_pop = 0; char_tick = 0;
  endtask

  task automatic fcr(input logic [7:0] d);
    fcr_wr = 1; fcr_wdata = d; step();
  endtask

  task automatic rxp(input logic [7:0] d);
    rx_push = 1; rx_push_data = d; step();
  endtask

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1;
    // R8 reset state
    chk(iir_rdata == 8'h01, "R8 reset iir", iir_rdata, 8'h01);
    chk(rx_empty && tx_empty && !irq, "R8 reset flags", {rx_empty, tx_empty, irq}, 3'b110);
    @(negedge clk);

    // R4 single-byte mode: one byte interrupts, second push overruns
    ie_rx = 1; ie_tx = 1;
    rxp(8'h3C);
    chk(iir_rdata[3:0] == 4'b0100, "R4 single level", iir_rdata[3:0], 4'b0100);
    rxp(8'h77);
    // R1 bits other than bit 0 ignored when bit 0 is 0
    fcr(8'h06);
    chk(!rx_empty && rx_pop_data == 8'h3C, "R1 ignored flush", rx_pop_data, 8'h3C);

    // R8/R4 queue mode, level 14
    fcr(8'hC7);
    chk(iir_rdata[7:6] == 2'b11, "R8 mode bits", iir_rdata[7:6], 2'b11);
    chk(rx_empty, "R1 mode change flush", rx_empty, 1);
    for (int i = 0; i < 13; i++) rxp(8'(i + 1));
    chk(iir_rdata[3:0] != 4'b0100, "R4 below 14", iir_rdata[3:0], 4'b0001);
    rxp(8'd14);
    chk(iir_rdata[3:0] == 4'b0100, "R4 at 14", iir_rdata[3:0], 4'b0100);
    rxp(8'd15); rxp(8'd16); rxp(8'd17);
    chk(rx_pop_data == 8'd1, "R3 oldest kept", rx_pop_data, 1);
    rx_pop = 1; step();
    chk(iir_rdata[3:0] == 4'b0100, "R4 still at 15", iir_rdata[3:0], 4'b0100);

    // R5 timeout at level 14 with a few bytes
    fcr(8'hC3);
    rxp(8'hA5); rxp(8'h5A);
    for (int i = 0; i < 3; i++) begin char_tick = 1; step(); end
    chk(iir_rdata[3:0] == 4'b0001, "R5 not yet", iir_rdata[3:0], 4'b0001);
    char_tick = 1; step();
    chk(iir_rdata == 8'hCC, "R5 timeout", iir_rdata, 8'hCC);
    rx_pop = 1; step();
    chk(iir_rdata[3:0] == 4'b0001, "R5 pop clears", iir_rdata[3:0], 4'b0001);

    // R6 transmit empty
    tx_push = 1; tx_push_data = 8'h11; step();
    tx_push = 1; tx_push_data = 8'h22; step();
    tx_pop = 1; step();
    chk(iir_rdata[3:0] == 4'b0001, "R6 not empty yet", iir_rdata[3:0], 4'b0001);
    tx_pop = 1; step();
    chk(iir_rdata[3:0] == 4'b0010 && irq, "R6 drained", iir_rdata[3:0], 4'b0010);
    iir_rd = 1; step();
    chk(iir_rdata[3:0] == 4'b0001, "R6 read clears", iir_rdata[3:0], 4'b0001);
    tx_pop = 1; step();
    chk(tx_empty, "R9 empty pop ignored", tx_empty, 1);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom_range(0, 99);
      rx_push = ($urandom_range(0, 99) < 45);
      rx_push_data = 8'($urandom);
      rx_pop = ($urandom_range(0, 99) < 35);
      tx_push = ($urandom_range(0, 99) < 40);
      tx_push_data = 8'($urandom);
      tx_pop = ($urandom_range(0, 99) < 40);
      char_tick = ($urandom_range(0, 99) < 30);
      iir_rd = ($urandom_range(0, 99) < 20);
      if (r < 3) begin
        fcr_wr = 1;
        fcr_wdata = 8'($urandom);
        if ($urandom_range(0, 3) != 0) fcr_wdata[0] = 1;
      end
      if (r == 50) ie_rx = $urandom_range(0, 1);
      if (r == 51) ie_tx = $urandom_range(0, 1);
      if (n % 500 < 40) begin rx_pop = 0; rx_push = 0; end
      step();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule